// File: doc/BRIEF.md
# Power-On EEPROM Boot Loader

This block runs once after reset. It reads a serial EEPROM through a simple byte-read handshake and decides whether the EEPROM holds a bootable image. A valid image starts with a fixed signature byte. The block then copies the image payload into on-chip RAM. When the copy is complete it sets the enumeration-mode flag, so that firmware takes over control-endpoint traffic, and it releases the embedded CPU from reset.

If no EEPROM answers, the block stops in a terminal idle state. It does the same if the signature is wrong or any read is refused. In that state the CPU stays in reset and the enumeration-mode flag stays clear, so the device core keeps handling enumeration itself.

The image layout after the signature has three parts: a 16-bit payload length, then a 16-bit RAM start address, then the payload bytes. Both 16-bit fields are sent low byte first. While it is working, the block owns the RAM write port and raises a busy flag.

Top module: `boot_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `enum_mode` is 0, `cpu_reset` is 1, `busy` is 1 and `ram_we` is 0. The first read is requested at EEPROM address 0.
- R2: A no-acknowledge (`rd_nak`=1 with `rd_done`=1) on the read of address 0 ends the run. `busy` falls, `enum_mode` stays 0, `cpu_reset` stays 1 and nothing is written to RAM.
- R3: If byte 0 differs from the signature (default 0xB2), the run ends with the same outcome as R2. No further read is issued.
- R4: Bytes 1 and 2 form the payload length and bytes 3 and 4 form the RAM start address, each low byte first. Payload byte k, read at EEPROM address 5+k, is written to RAM address start+k.
- R5: Reads are issued at consecutive EEPROM addresses starting at 0. A request holds `rd_req` high and `rd_addr` steady until `rd_done` is seen.
- R6: After a valid image, `enum_mode` goes to 1 and `cpu_reset` goes to 0 in the same cycle, and only after the last RAM write. No RAM write occurs while the CPU is out of reset.
- R7: A payload length of zero completes the load with no RAM write.
- R8: A no-acknowledge on any header or payload read ends the run with the outcome of R2. Writes already made stay made, and no further writes follow.
- R9: Once `busy` has fallen, the outcome is frozen until the next reset: no reads, no writes, and the flags do not change.
- R10: `ram_we` is asserted only while `busy` is 1.
- R11: The RAM write address wraps modulo 2^RAM_AW when start+k passes the top of RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Byte read request, held until `rd_done` |
| rd_addr | output | EE_AW | EEPROM byte address of the request |
| rd_done | input | 1 | One-cycle completion strobe of a read |
| rd_nak | input | 1 | Read was not acknowledged; valid with `rd_done` |
| rd_data | input | 8 | Byte read; valid with `rd_done` |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | High from reset until the terminal state |
| enum_mode | output | 1 | 1 when firmware handles enumeration |
| cpu_reset | output | 1 | 1 holds the embedded CPU in reset |

## Verification
The assertions assume that the read agent raises `rd_done` for one cycle only, and only in reply to a pending `rd_req`. They also assume that `rd_nak` and `rd_data` have meaning only in that cycle. The bench EEPROM model answers each request once, after a fixed latency, and drops `rd_done` on the next cycle. It never strobes while the loader is idle or in reset, so every completion the design sees belongs to the request it has outstanding.

// File: rtl/boot_pkg.sv
package boot_pkg;

   typedef enum logic [2:0] {
      ST_SIG  = 3'd0,
      ST_CNTL = 3'd1,
      ST_CNTH = 3'd2,
      ST_ADRL = 3'd3,
      ST_ADRH = 3'd4,
      ST_DATA = 3'd5,
      ST_OK   = 3'd6,
      ST_FAIL = 3'd7
   } boot_state_e;

   localparam int HDR_BYTES = 5;

endpackage

// File: rtl/boot_seq.sv
module boot_seq
   import boot_pkg::*;
#(
   parameter int          EE_AW  = 16,
   parameter int          RAM_AW = 13,
   parameter logic [7:0]  SIG    = 8'hB2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [EE_AW-1:0]  rd_addr,
   input  logic              rd_done,
   input  logic              rd_nak,
   input  logic [7:0]        rd_data,
   output logic              wr_fire,
   output logic [RAM_AW-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              fin_ok,
   output logic              fin_fail
);

   boot_state_e        state_q;
   logic [EE_AW-1:0]   ee_addr_q;
   logic [7:0]         lo_q;
   logic [15:0]        remain_q;
   logic [RAM_AW-1:0]  base_q;
   logic [RAM_AW-1:0]  offs_q;
   logic               take;

   assign rd_req   = (state_q != ST_OK) && (state_q != ST_FAIL);
   assign rd_addr  = ee_addr_q;
   assign take     = rd_req && rd_done;
   assign wr_fire  = take && !rd_nak && (state_q == ST_DATA);
   assign wr_addr  = base_q + offs_q;
   assign wr_data  = rd_data;
   assign fin_ok   = (state_q == ST_OK);
   assign fin_fail = (state_q == ST_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_SIG;
         ee_addr_q <= '0;
         lo_q      <= '0;
         remain_q  <= '0;
         base_q    <= '0;
         offs_q    <= '0;
      end else if (take) begin
         ee_addr_q <= ee_addr_q + 1'b1;
         if (rd_nak) begin
            state_q <= ST_FAIL;
         end else begin
            unique case (state_q)
               ST_SIG:  state_q <= (rd_data == SIG) ? ST_CNTL : ST_FAIL;
               ST_CNTL: begin lo_q <= rd_data; state_q <= ST_CNTH; end
               ST_CNTH: begin remain_q <= {rd_data, lo_q}; state_q <= ST_ADRL; end
               ST_ADRL: begin lo_q <= rd_data; state_q <= ST_ADRH; end
               ST_ADRH: begin
                  base_q  <= RAM_AW'({rd_data, lo_q});
                  offs_q  <= '0;
                  state_q <= (remain_q == 16'd0) ? ST_OK : ST_DATA;
               end
               ST_DATA: begin
                  offs_q   <= offs_q + 1'b1;
                  remain_q <= remain_q - 16'd1;
                  if (remain_q == 16'd1) state_q <= ST_OK;
               end
               default: ;
            endcase
         end
      end
   end

   // R5: an outstanding request is held with a steady address
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr)));

   // R8: any refused read drops the sequencer into the failure state
   assert_nak_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_done && rd_nak) |=> (state_q == ST_FAIL));

   // R3: a wrong signature byte is rejected
   assert_sig_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_done && !rd_nak && state_q == ST_SIG && rd_data != SIG)
      |=> (state_q == ST_FAIL && !rd_req));

   // R9: terminal states are sticky
   assert_final_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_ok || fin_fail) |=> ($stable(state_q) && !rd_req));

endmodule

// File: rtl/boot_wr_stage.sv
module boot_wr_stage #(
   parameter int RAM_AW = 13,
   parameter bit REG_WR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_we,
   input  logic [RAM_AW-1:0] in_addr,
   input  logic [7:0]        in_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata
);

   generate
      if (REG_WR) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ram_we    <= 1'b0;
               ram_addr  <= '0;
               ram_wdata <= '0;
            end else begin
               ram_we <= in_we;
               if (in_we) begin
                  ram_addr  <= in_addr;
                  ram_wdata <= in_data;
               end
            end
         end
      end else begin : g_pass
         assign ram_we    = in_we;
         assign ram_addr  = in_addr;
         assign ram_wdata = in_data;
      end
   endgenerate

endmodule

// File: rtl/boot_status.sv
module boot_status (
   input  logic clk,
   input  logic rst_n,
   input  logic fin_ok,
   input  logic fin_fail,
   output logic busy,
   output logic enum_mode,
   output logic cpu_reset
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b1;
         enum_mode <= 1'b0;
         cpu_reset <= 1'b1;
      end else begin
         busy <= busy && !(fin_ok || fin_fail);
         if (fin_ok) begin
            enum_mode <= 1'b1;
            cpu_reset <= 1'b0;
         end
      end
   end

   // R6: a finished load releases the CPU and flips the mode flag
   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fin_ok |=> (enum_mode && !cpu_reset && !busy));

   // R2: a failed run keeps the CPU held and the flag clear
   assert_fail_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_fail && !fin_ok) |=> (!enum_mode && cpu_reset && !busy));

endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
   parameter int          EE_AW  = 16,
   parameter int          RAM_AW = 13,
   parameter logic [7:0]  SIG    = 8'hB2,
   parameter bit          REG_WR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [EE_AW-1:0]  rd_addr,
   input  logic              rd_done,
   input  logic              rd_nak,
   input  logic [7:0]        rd_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              busy,
   output logic              enum_mode,
   output logic              cpu_reset
);

   generate
      if (RAM_AW < 1 || RAM_AW > 16) begin : g_bad_ram
         $error("boot_loader: RAM_AW must lie in 1..16");
      end
      if (EE_AW < 3) begin : g_bad_ee
         $error("boot_loader: EE_AW too small for the header");
      end
   endgenerate

   logic              wr_fire;
   logic [RAM_AW-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic              fin_ok;
   logic              fin_fail;

   boot_seq #(.EE_AW(EE_AW), .RAM_AW(RAM_AW), .SIG(SIG)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_done(rd_done), .rd_nak(rd_nak), .rd_data(rd_data),
      .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
      .fin_ok(fin_ok), .fin_fail(fin_fail)
   );

   boot_wr_stage #(.RAM_AW(RAM_AW), .REG_WR(REG_WR)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .in_we(wr_fire), .in_addr(wr_addr), .in_data(wr_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   boot_status u_st (
      .clk(clk), .rst_n(rst_n),
      .fin_ok(fin_ok), .fin_fail(fin_fail),
      .busy(busy), .enum_mode(enum_mode), .cpu_reset(cpu_reset)
   );

   // R10: the RAM port is driven only while the loader owns it
   assert_we_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy);

   // R6: no write lands after the CPU has been released
   assert_we_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (cpu_reset && !enum_mode));

endmodule

// File: tb/boot_loader_test.sv
module boot_loader_test;

   localparam int CLK_PERIOD = 10;
   localparam int EE_AW  = 16;
   localparam int RAM_AW = 13;
   localparam int LAT    = 2;
   localparam int NVEC   = 8;

   // {signature, length, start, nak index (FF = none)}
   localparam logic [47:0] VEC [NVEC] = '{
      {8'hB2, 16'd4,  16'h0100, 8'hFF},
      {8'hB2, 16'd0,  16'h0200, 8'hFF},
      {8'hA5, 16'd4,  16'h0000, 8'hFF},
      {8'hB2, 16'd3,  16'h1FFE, 8'hFF},
      {8'hB2, 16'd6,  16'h0040, 8'h00},
      {8'hB2, 16'd6,  16'h0040, 8'h02},
      {8'hB2, 16'd6,  16'h0040, 8'h07},
      {8'hB2, 16'd20, 16'h0300, 8'hFF}
   };
   string tags [NVEC] = '{"R4", "R7", "R3", "R11", "R2", "R8", "R8", "R4"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_req;
   logic [EE_AW-1:0] rd_addr;
   logic rd_done = 1'b0;
   logic rd_nak = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic ram_we;
   logic [RAM_AW-1:0] ram_addr;
   logic [7:0] ram_wdata;
   logic busy, enum_mode, cpu_reset;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0]  cur_sig;
   logic [15:0] cur_cnt;
   logic [15:0] cur_start;
   logic [7:0]  cur_nak;
   int nread = 0;
   int addr_err = 0;
   int nwr = 0;
   int order_err = 0;
   int wl_addr [64];
   int wl_data [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_loader #(.EE_AW(EE_AW), .RAM_AW(RAM_AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_done(rd_done), .rd_nak(rd_nak), .rd_data(rd_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .busy(busy), .enum_mode(enum_mode), .cpu_reset(cpu_reset)
   );

   function automatic logic [7:0] ee_byte(input int a);
      case (a)
         0: return cur_sig;
         1: return cur_cnt[7:0];
         2: return cur_cnt[15:8];
         3: return cur_start[7:0];
         4: return cur_start[15:8];
         default: return 8'((a * 5 + 1) & 255);
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // EEPROM agent: answers each request once after LAT cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rd_req) begin
            int a;
            a = int'(rd_addr);
            if (a != nread) addr_err++;
            repeat (LAT) @(negedge clk);
            rd_data = ee_byte(a);
            rd_nak  = (cur_nak != 8'hFF) && (nread == int'(cur_nak));
            rd_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0;
            rd_nak  = 1'b0;
            nread++;
         end
      end
   end

   // RAM write monitor
   always @(negedge clk) begin
      if (rst_n && ram_we) begin
         if (nwr < 64) begin
            wl_addr[nwr] = int'(ram_addr);
            wl_data[nwr] = int'(ram_wdata);
         end
         nwr++;
         if (!cpu_reset || enum_mode || !busy) order_err++;
      end
   end

   task automatic run_vec(input int i);
      int t;
      int exp_reads, exp_wr, bad;
      bit sig_ok, nak, exp_ok;
      cur_sig   = VEC[i][47:40];
      cur_cnt   = VEC[i][39:24];
      cur_start = VEC[i][23:8];
      cur_nak   = VEC[i][7:0];
      rst_n = 1'b0;
      nread = 0; addr_err = 0; nwr = 0; order_err = 0;
      repeat (3) @(negedge clk);
      if (i == 0) begin
         chk("R1", "busy in reset", int'(busy), 1);
         chk("R1", "cpu_reset in reset", int'(cpu_reset), 1);
      end
      @(posedge clk);
      rst_n <= 1'b1;
      @(negedge clk);
      if (i == 0) begin
         chk("R1", "first rd_req", int'(rd_req), 1);
         chk("R1", "first rd_addr", int'(rd_addr), 0);
         chk("R1", "enum_mode after reset", int'(enum_mode), 0);
         chk("R1", "ram_we after reset", int'(ram_we), 0);
      end
      t = 0;
      while (busy && t < 5000) begin @(negedge clk); t++; end
      chk("R9", "busy fell", int'(busy), 0);
      repeat (10) @(negedge clk);

      sig_ok = (cur_sig == 8'hB2);
      nak    = (cur_nak != 8'hFF);
      exp_ok = sig_ok && !nak;
      if (nak) exp_reads = int'(cur_nak) + 1;
      else if (!sig_ok) exp_reads = 1;
      else exp_reads = 5 + int'(cur_cnt);
      if (exp_ok) exp_wr = int'(cur_cnt);
      else if (nak && cur_nak >= 8'd5) exp_wr = int'(cur_nak) - 5;
      else exp_wr = 0;

      chk(tags[i], "enum_mode", int'(enum_mode), int'(exp_ok));
      chk(tags[i], "cpu_reset", int'(cpu_reset), int'(!exp_ok));
      chk("R5", "read count", nread, exp_reads);
      chk("R5", "read address errors", addr_err, 0);
      chk("R9", "rd_req idle", int'(rd_req), 0);
      chk(tags[i], "write count", nwr, exp_wr);
      chk("R6", "writes outside load window", order_err, 0);
      bad = 0;
      for (int k = 0; k < exp_wr && k < nwr && k < 64; k++) begin
         if (wl_addr[k] != ((int'(cur_start) + k) & ((1 << RAM_AW) - 1))) bad++;
         if (wl_data[k] != int'(ee_byte(5 + k))) bad++;
      end
      chk(tags[i], "write content mismatches", bad, 0);
   endtask

   initial begin
      for (int i = 0; i < NVEC; i++) run_vec(i);

      // R9: outcome frozen well after completion
      repeat (40) @(negedge clk);
      chk("R9", "late reads", nread, 5 + 20);
      chk("R9", "late writes", nwr, 20);
      chk("R9", "late enum_mode", int'(enum_mode), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog: busy=%0d expected 0", busy);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule